// File: doc/BRIEF.md
# Complementary PWM Generator with Programmable Dead Time

This block drives one complementary pair of PWM outputs from a 16-bit up-counter. The counter runs from zero to a period limit and then wraps. The limit comes from one of two places: a period value shared by several generators, or the block's own period register. The high-side output is active while the counter is below the active duty value. The low-side output is its complement. A dead-time stage then reshapes both outputs.

Software writes to the block through simple write strobes over a shared data bus. It can write the configuration byte, the local period, the local duty, the master duty and the trigger compare value. Duty writes pass through a clamp into a buffer. The buffer reaches the active compare value either at once or only at the next counter wrap. An external current-limit signal can hold the local time base at zero. The block also raises two flags with enables: a trigger compare flag and a current-limit flag.

Top module: `cpwm_gen`

## Requirements
- R1: While `rst_ni` is low, `cnt_o`, both PWM outputs, both flags and both interrupt pulses are 0. Reset also clears the configuration, period, duty and trigger registers.
- R2: The counter steps up by one per clock from 0 to the selected period and then returns to 0. Configuration bit 2 selects the period source: 1 selects the local period register, and 0 selects `pri_period_i`.
- R3: With dead time disabled, `pwm_h_o` one cycle after a counter value `k` equals `k < active duty`, and `pwm_l_o` is its inverse. Configuration bit 3 selects the duty source: 1 selects the master duty register, and 0 selects the local duty register.
- R4: Every duty write is clamped to the range 0x0008 to 0xFFEF. A write of 3 therefore acts as 8.
- R5: Configuration bit 4 sets the update mode. When it is 1, the buffered duty becomes active on the next cycle. When it is 0, the buffered duty becomes active only at the counter wrap, and a mid-period write leaves the current period unchanged.
- R6: Configuration bits 1:0 select the dead-time mode: 00 is positive, 01 is negative, and 10 or 11 disables dead time. When dead time is disabled, the two outputs are always complementary.
- R7: In positive mode, each output rises `dt_cnt_i` cycles after its raw phase begins. Both outputs are low during that gap.
- R8: In negative mode, each output stays high for `dt_cnt_i` cycles into the other phase. Both outputs are high during that overlap.
- R9: Configuration bit 5 enables the current-limit restart. When bit 5 and bit 2 are both 1, a high `cur_lim_i` forces the counter to 0. In every other case, `cur_lim_i` has no effect on the counter.
- R10: With configuration bit 6 set, a counter value equal to the trigger register produces a one-cycle `trg_irq_o` pulse and sets `trg_flag_o`. With bit 6 clear, a match does neither.
- R11: With configuration bit 7 set, a rising edge on `cur_lim_i` produces a one-cycle `cl_irq_o` pulse and sets `cl_flag_o`.
- R12: Clearing an interrupt enable clears its status flag one cycle after the configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the configuration byte (`wdata_i[7:0]`) |
| per_we_i | input | 1 | Write strobe for the local period register |
| duty_we_i | input | 1 | Write strobe for the local duty register |
| mduty_we_i | input | 1 | Write strobe for the master duty register |
| trig_we_i | input | 1 | Write strobe for the trigger compare register |
| wdata_i | input | 16 | Write data shared by all strobes |
| pri_period_i | input | 16 | Shared primary period |
| dt_cnt_i | input | 8 | Dead-time length in clock cycles |
| cur_lim_i | input | 1 | Current-limit input |
| cnt_o | output | 16 | Time-base count |
| pwm_h_o | output | 1 | High-side output |
| pwm_l_o | output | 1 | Low-side output |
| trg_flag_o | output | 1 | Trigger status flag |
| trg_irq_o | output | 1 | Trigger interrupt pulse |
| cl_flag_o | output | 1 | Current-limit status flag |
| cl_irq_o | output | 1 | Current-limit interrupt pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the counter only ever increments by one or returns to zero;
- the active duty value stays inside the clamp range;
- the outputs never overlap in positive mode and are always complementary when dead time is disabled;
- an interrupt pulse never appears without its flag;
- a cleared enable leaves its flag low.

Other behaviour can only be shown by the bench scenarios:
- the exact edge positions for a given duty value and dead-time count;
- the choice between the two period sources and the two duty sources;
- the difference between immediate and wrap-aligned duty loading;
- a current-limit input that is ignored outside its enabled mode.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    DT_POS = 2'b00,
    DT_NEG = 2'b01,
    DT_OFF = 2'b10,
    DT_RSV = 2'b11
  } dt_mode_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic     clie;
    logic     trgie;
    logic     xres;
    logic     iue;
    logic     mdsel;
    logic     itb;
    dt_mode_e dt;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          itb_i,
  input  logic          xres_i,
  input  logic          cur_lim_i,
  input  logic          per_we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [CW-1:0] pri_period_i,
  output logic [CW-1:0] cnt_o,
  output logic          roll_o
);
  logic [CW-1:0] per_q, cnt_q, period;
  logic          ext_clr;

  assign period  = itb_i ? per_q : pri_period_i;
  assign roll_o  = (cnt_q >= period);
  assign ext_clr = xres_i & itb_i & cur_lim_i;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      cnt_q <= '0;
    end else begin
      if (per_we_i) per_q <= wdata_i;
      if (ext_clr || roll_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/cpwm_duty.sv
module cpwm_duty #(
  parameter int unsigned CW       = 16,
  parameter int unsigned DUTY_MIN = 16'h0008,
  parameter int unsigned DUTY_MAX = 16'hFFEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          duty_we_i,
  input  logic          mduty_we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          mdsel_i,
  input  logic          iue_i,
  input  logic          roll_i,
  output logic [CW-1:0] active_o
);
  localparam logic [CW-1:0] LO = CW'(DUTY_MIN);
  localparam logic [CW-1:0] HI = CW'(DUTY_MAX);

  logic [CW-1:0] buf_q, mbuf_q, act_q, src, wclamp;

  always_comb begin
    if (wdata_i < LO)      wclamp = LO;
    else if (wdata_i > HI) wclamp = HI;
    else                   wclamp = wdata_i;
  end

  assign src      = mdsel_i ? mbuf_q : buf_q;
  assign active_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      mbuf_q <= '0;
      act_q  <= '0;
    end else begin
      if (duty_we_i)  buf_q  <= wclamp;
      if (mduty_we_i) mbuf_q <= wclamp;
      if (iue_i || roll_i) act_q <= src;
    end
  end
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
  import cpwm_pkg::*;
#(
  parameter int unsigned DTW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           raw_h_i,
  input  dt_mode_e       mode_i,
  input  logic [DTW-1:0] dt_i,
  output logic           h_o,
  output logic           l_o
);
  logic [1:0]     raw;
  logic [DTW-1:0] run [2];
  logic           h_d, l_d, h_q, l_q;

  assign raw = {~raw_h_i, raw_h_i};

  // run[g]: cycles phase g has already been active, saturating
  for (genvar g = 0; g < 2; g++) begin : g_run
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            run[g] <= '0;
      else if (!raw[g])       run[g] <= '0;
      else if (run[g] != '1)  run[g] <= run[g] + DTW'(1);
    end
  end

  always_comb begin
    unique case (mode_i)
      DT_POS: begin
        h_d = raw[0] && (run[0] >= dt_i);
        l_d = raw[1] && (run[1] >= dt_i);
      end
      DT_NEG: begin
        h_d = raw[0] || (raw[1] && (run[1] < dt_i));
        l_d = raw[1] || (raw[0] && (run[0] < dt_i));
      end
      default: begin
        h_d = raw[0];
        l_d = raw[1];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= 1'b0;
      l_q <= 1'b0;
    end else begin
      h_q <= h_d;
      l_q <= l_d;
    end
  end

  assign h_o = h_q;
  assign l_o = l_q;
endmodule

// File: rtl/cpwm_events.sv
module cpwm_events #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          trig_we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          trgie_i,
  input  logic          clie_i,
  input  logic          cur_lim_i,
  output logic          trg_flag_o,
  output logic          trg_irq_o,
  output logic          cl_flag_o,
  output logic          cl_irq_o
);
  logic [CW-1:0] trig_q;
  logic          cl_d, trg_hit, cl_rise;

  assign trg_hit = (cnt_i == trig_q);
  assign cl_rise = cur_lim_i & ~cl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q     <= '0;
      cl_d       <= 1'b0;
      trg_flag_o <= 1'b0;
      trg_irq_o  <= 1'b0;
      cl_flag_o  <= 1'b0;
      cl_irq_o   <= 1'b0;
    end else begin
      if (trig_we_i) trig_q <= wdata_i;
      cl_d      <= cur_lim_i;
      trg_irq_o <= trgie_i & trg_hit;
      cl_irq_o  <= clie_i & cl_rise;
      if (!trgie_i)     trg_flag_o <= 1'b0;
      else if (trg_hit) trg_flag_o <= 1'b1;
      if (!clie_i)      cl_flag_o  <= 1'b0;
      else if (cl_rise) cl_flag_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned DTW      = 8,
  parameter int unsigned DUTY_MIN = 16'h0008,
  parameter int unsigned DUTY_MAX = 16'hFFEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic           per_we_i,
  input  logic           duty_we_i,
  input  logic           mduty_we_i,
  input  logic           trig_we_i,
  input  logic [CW-1:0]  wdata_i,
  input  logic [CW-1:0]  pri_period_i,
  input  logic [DTW-1:0] dt_cnt_i,
  input  logic           cur_lim_i,
  output logic [CW-1:0]  cnt_o,
  output logic           pwm_h_o,
  output logic           pwm_l_o,
  output logic           trg_flag_o,
  output logic           trg_irq_o,
  output logic           cl_flag_o,
  output logic           cl_irq_o
);
  cfg_t          cfg_q;
  logic [CW-1:0] cnt, active_duty;
  logic          roll, raw_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
  end

  cpwm_timebase #(.CW(CW)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .itb_i(cfg_q.itb), .xres_i(cfg_q.xres),
    .cur_lim_i(cur_lim_i), .per_we_i(per_we_i), .wdata_i(wdata_i),
    .pri_period_i(pri_period_i), .cnt_o(cnt), .roll_o(roll)
  );

  cpwm_duty #(.CW(CW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_duty (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_we_i(duty_we_i), .mduty_we_i(mduty_we_i),
    .wdata_i(wdata_i), .mdsel_i(cfg_q.mdsel), .iue_i(cfg_q.iue), .roll_i(roll),
    .active_o(active_duty)
  );

  assign raw_h = (cnt < active_duty);

  cpwm_deadtime #(.DTW(DTW)) u_dt (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_h_i(raw_h), .mode_i(cfg_q.dt),
    .dt_i(dt_cnt_i), .h_o(pwm_h_o), .l_o(pwm_l_o)
  );

  cpwm_events #(.CW(CW)) u_ev (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .trig_we_i(trig_we_i),
    .wdata_i(wdata_i), .trgie_i(cfg_q.trgie), .clie_i(cfg_q.clie),
    .cur_lim_i(cur_lim_i), .trg_flag_o(trg_flag_o), .trg_irq_o(trg_irq_o),
    .cl_flag_o(cl_flag_o), .cl_irq_o(cl_irq_o)
  );

  assign cnt_o = cnt;
endmodule

// File: rtl/cpwm_gen_chk.sv
module cpwm_gen_chk
  import cpwm_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned DUTY_MIN = 16'h0008,
  parameter int unsigned DUTY_MAX = 16'hFFEF
) (
  input logic          clk_i,
  input logic          rst_ni,
  input cfg_t          cfg_i,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] active_i,
  input logic          h_i,
  input logic          l_i,
  input logic          trg_flag_i,
  input logic          trg_irq_i,
  input logic          cl_flag_i,
  input logic          cl_irq_i
);
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> (cnt_i == $past(cnt_i) + CW'(1)));

  assert_duty_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i != '0) |-> (active_i >= CW'(DUTY_MIN) && active_i <= CW'(DUTY_MAX)));

  assert_off_compl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.dt == DT_OFF && $past(cfg_i.dt) == DT_OFF) |-> (h_i != l_i));

  assert_pos_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.dt == DT_POS && $past(cfg_i.dt) == DT_POS) |-> !(h_i && l_i));

  assert_trg_irq_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_irq_i |-> trg_flag_i);

  assert_cl_irq_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl_irq_i |-> cl_flag_i);

  assert_trg_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_i.trgie) |-> !trg_flag_i);

  assert_cl_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_i.clie) |-> !cl_flag_i);
endmodule

bind cpwm_gen cpwm_gen_chk #(.CW(CW), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_q), .cnt_i(cnt_o), .active_i(active_duty),
  .h_i(pwm_h_o), .l_i(pwm_l_o), .trg_flag_i(trg_flag_o), .trg_irq_i(trg_irq_o),
  .cl_flag_i(cl_flag_o), .cl_irq_i(cl_irq_o)
);

// File: tb/sim_cpwm_gen.sv
module sim_cpwm_gen;
  localparam int S_CNT = 0, S_H = 1, S_L = 2, S_TF = 3, S_TI = 4, S_CF = 5, S_CI = 6;
  localparam int W_CFG = 0, W_PER = 1, W_DUTY = 2, W_MDUTY = 3, W_TRIG = 4;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 0, per_we = 0, duty_we = 0, mduty_we = 0, trig_we = 0;
  logic [15:0] wdata = '0, pri_period = 16'd5;
  logic [7:0]  dt_cnt = '0;
  logic        cur_lim = 1'b0;
  logic [15:0] cnt;
  logic        h, l, tf, ti, cf, ci;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int    sel_q[$];
  int    exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;

  cpwm_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .per_we_i(per_we),
    .duty_we_i(duty_we), .mduty_we_i(mduty_we), .trig_we_i(trig_we),
    .wdata_i(wdata), .pri_period_i(pri_period), .dt_cnt_i(dt_cnt),
    .cur_lim_i(cur_lim), .cnt_o(cnt), .pwm_h_o(h), .pwm_l_o(l),
    .trg_flag_o(tf), .trg_irq_o(ti), .cl_flag_o(cf), .cl_irq_o(ci)
  );

  function automatic int observe(int s);
    case (s)
      S_CNT:   return int'(cnt);
      S_H:     return int'(h);
      S_L:     return int'(l);
      S_TF:    return int'(tf);
      S_TI:    return int'(ti);
      S_CF:    return int'(cf);
      default: return int'(ci);
    endcase
  endfunction

  // expectation for the state after the next rising edge
  task automatic push(int s, int e, string r);
    sel_q.push_back(s);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  // monitor: pops expectations after each edge
  initial forever begin
    @(posedge clk);
    #5;
    while (sel_q.size() > 0) begin
      int s, e, a;
      string r;
      s = sel_q.pop_front();
      e = exp_q.pop_front();
      r = req_q.pop_front();
      a = observe(s);
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", r, s, a, e);
      end
    end
  end

  task automatic wr(int which, logic [15:0] d);
    wdata = d;
    case (which)
      W_CFG:   cfg_we = 1;
      W_PER:   per_we = 1;
      W_DUTY:  duty_we = 1;
      W_MDUTY: mduty_we = 1;
      default: trig_we = 1;
    endcase
    @(negedge clk);
    {cfg_we, per_we, duty_we, mduty_we, trig_we} = '0;
  endtask

  task automatic sync_cnt(int v);
    for (int i = 0; i < 300; i++) begin
      if (int'(cnt) == v) return;
      @(negedge clk);
    end
    n_chk++;
    n_fail++;
    $display("FAIL sync actual=%0d expected=%0d", cnt, v);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    push(S_CNT, 0, "R1"); push(S_H, 0, "R1"); push(S_L, 0, "R1");
    push(S_TF, 0, "R1"); push(S_TI, 0, "R1"); push(S_CF, 0, "R1"); push(S_CI, 0, "R1");
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 primary period, then local period
    sync_cnt(5); push(S_CNT, 0, "R2"); @(negedge clk);
    push(S_CNT, 1, "R2");
    push(S_TF, 0, "R10 disabled"); @(negedge clk);
    wr(W_PER, 16'd39);
    wr(W_CFG, 16'h16);
    wr(W_DUTY, 16'd20);
    sync_cnt(39); push(S_CNT, 0, "R2 local"); @(negedge clk);

    // R3 / R6 local duty, dead time off
    sync_cnt(19); push(S_H, 1, "R3"); push(S_L, 0, "R6"); @(negedge clk);
    push(S_H, 0, "R3"); push(S_L, 1, "R6"); @(negedge clk);

    // R3 master duty
    wr(W_MDUTY, 16'd30);
    wr(W_CFG, 16'h1E);
    sync_cnt(39); sync_cnt(29); push(S_H, 1, "R3 master"); @(negedge clk);
    push(S_H, 0, "R3 master"); @(negedge clk);

    // R4 low clamp
    wr(W_CFG, 16'h16);
    wr(W_DUTY, 16'd3);
    sync_cnt(39); sync_cnt(7); push(S_H, 1, "R4"); @(negedge clk);
    push(S_H, 0, "R4"); @(negedge clk);

    // R5 wrap-aligned update
    wr(W_CFG, 16'h06);
    sync_cnt(39); sync_cnt(2);
    wr(W_DUTY, 16'd20);
    sync_cnt(7); push(S_H, 1, "R5 held"); @(negedge clk);
    push(S_H, 0, "R5 held"); @(negedge clk);
    sync_cnt(19); push(S_H, 0, "R5 held"); @(negedge clk);
    sync_cnt(39); sync_cnt(19); push(S_H, 1, "R5 applied"); @(negedge clk);
    push(S_H, 0, "R5 applied"); @(negedge clk);

    // R7 positive dead time
    dt_cnt = 8'd3;
    wr(W_CFG, 16'h04);
    sync_cnt(39); sync_cnt(2); push(S_H, 0, "R7"); push(S_L, 0, "R7"); @(negedge clk);
    push(S_H, 1, "R7"); push(S_L, 0, "R7"); @(negedge clk);
    sync_cnt(21); push(S_H, 0, "R7"); push(S_L, 0, "R7"); @(negedge clk);
    sync_cnt(23); push(S_H, 0, "R7"); push(S_L, 1, "R7"); @(negedge clk);

    // R8 negative dead time
    wr(W_CFG, 16'h05);
    sync_cnt(39); sync_cnt(1); push(S_H, 1, "R8"); push(S_L, 1, "R8"); @(negedge clk);
    sync_cnt(21); push(S_H, 1, "R8"); push(S_L, 1, "R8"); @(negedge clk);
    sync_cnt(23); push(S_H, 0, "R8"); push(S_L, 1, "R8"); @(negedge clk);

    // R9 current-limit restart
    dt_cnt = 8'd0;
    wr(W_CFG, 16'h26);
    sync_cnt(10); cur_lim = 1; push(S_CNT, 0, "R9"); @(negedge clk);
    push(S_CNT, 0, "R9"); @(negedge clk);
    cur_lim = 0; push(S_CNT, 1, "R9"); @(negedge clk);
    wr(W_CFG, 16'h22);
    sync_cnt(3); cur_lim = 1; push(S_CNT, 4, "R9 ignored primary"); @(negedge clk);
    cur_lim = 0;
    wr(W_CFG, 16'h06);
    sync_cnt(3); cur_lim = 1; push(S_CNT, 4, "R9 ignored xres0"); @(negedge clk);
    cur_lim = 0; push(S_CF, 0, "R11 disabled"); @(negedge clk);

    // R10 trigger
    wr(W_TRIG, 16'd7);
    wr(W_CFG, 16'h46);
    sync_cnt(7); push(S_TI, 1, "R10"); push(S_TF, 1, "R10"); @(negedge clk);
    push(S_TI, 0, "R10"); push(S_TF, 1, "R10"); @(negedge clk);
    wr(W_CFG, 16'h06);
    push(S_TF, 0, "R12 trigger"); @(negedge clk);

    // R11 current limit flag
    wr(W_CFG, 16'h86);
    cur_lim = 1; push(S_CI, 1, "R11"); push(S_CF, 1, "R11"); @(negedge clk);
    push(S_CI, 0, "R11"); push(S_CF, 1, "R11"); @(negedge clk);
    cur_lim = 0;
    wr(W_CFG, 16'h06);
    push(S_CF, 0, "R12 current limit"); @(negedge clk);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule